// File: doc/BRIEF.md
# Bit-serial/parallel FIR convolver

The block computes the one-dimensional linear convolution of a stream of unsigned 8-bit samples with eight unsigned 8-bit coefficients. Each coefficient is held as a parallel word inside its own tap multiplier. Samples arrive one bit per clock, least significant bit first. Each tap consumes the bits of its delayed sample serially. A registered carry/sum stage sits inside every multiplier. Between taps, a word-level delay line holds the previous samples. The product bits of all taps are weighted by their bit position and added into a full-precision output word once per sample period.

A host loads coefficients while the block is idle. It then streams a sequence of samples, one every 16 or more clocks, and flags the final sample. After the final sample, the block inserts seven zero sample periods by itself, so that every one of the M+7 results appears. Results come out in index order, each with a one-clock valid pulse. The delay line is empty again when the flush ends, so the next sequence starts from a clean history.

Top module: `bsp_conv`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, y_o is 0 and valid_o is 0.
- R2: Output word m equals the sum over n = 0..7 of h[n]·x[m-n]. Samples with index below 0 or at M or above count as zero. Data and coefficients are unsigned. The 19-bit result is exact, with no truncation or wrap.
- R3: A sample is entered by raising start_i for one clock while bit_i carries bit 0, then driving bits 1..7 on bit_i in the next seven clocks. A sample period lasts 16 clocks, and the next start_i may come no earlier than 16 clocks after the previous one.
- R4: Raising last_i together with start_i marks the final sample. The block then runs 7 zero sample periods back to back, so one sequence of M samples yields exactly M+7 valid words, ordered from y[0] upward.
- R5: valid_o is high for exactly one clock per result. For a sample started in clock K, it is high in clock K+16. For each inserted zero period, it is high 16 clocks after the previous result.
- R6: coef_we_i with coef_addr_i = n (3 bits, values 0..7) writes coef_data_i into h[n] when no sample period is running and no zero period is pending. Writes at other times are ignored, and the stored coefficient keeps its old value.
- R7: start_i is ignored while a sample period or the zero flush is in progress.
- R8: A sequence that starts after a completed flush sees all past samples as zero, so its first result is h[0]·x[0].
- R9: The all-0xFF case, with every coefficient and sample at 255, produces 520200 for each full-overlap output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 3 | Tap index of the coefficient write |
| coef_data_i | input | 8 | Coefficient value |
| bit_i | input | 1 | Serial sample data, LSB first |
| start_i | input | 1 | Marks bit 0 of a sample |
| last_i | input | 1 | Marks the final sample of a sequence, sampled with start_i |
| y_o | output | 19 | Convolution result word |
| valid_o | output | 1 | One-clock pulse when y_o holds a new result |

## Verification
The assertions assume that the host never starts a sample sooner than 16 clocks after the previous start. Under that assumption, valid pulses can never run together, and every result stays within eight times 255 squared. The bench always waits the full 16 clocks before the next start, adding random gaps of up to three clocks. It loads coefficients only when idle, apart from one deliberate write during streaming that tests R6. Its stray start_i during the flush is placed so that R7 governs what happens.

// File: rtl/bsp_conv_pkg.sv
package bsp_conv_pkg;
  localparam int unsigned DefDw   = 8;
  localparam int unsigned DefTaps = 8;

  // full-precision width of a sum of taps products of dw x dw bits
  function automatic int unsigned sum_width(int unsigned dw, int unsigned taps);
    return 2 * dw + $clog2(taps);
  endfunction
endpackage

// File: rtl/bsp_conv_mul.sv
module bsp_conv_mul #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          first_i,
  input  logic          d_i,
  input  logic [DW-1:0] coef_i,
  output logic          p_o
);
  logic [DW-1:0] acc_q;
  logic [DW-1:0] base;
  logic [DW:0]   sum;

  assign base = first_i ? '0 : acc_q;
  assign sum  = {1'b0, base} + (d_i ? {1'b0, coef_i} : '0);
  assign p_o  = sum[0];

  // registered carry/sum: (acc + h) >> 1 never exceeds DW bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum[DW:1];
  end
endmodule

// File: rtl/bsp_conv_ctrl.sv
module bsp_conv_ctrl #(
  parameter int unsigned NTAPS = 8,
  parameter int unsigned PER   = 16,
  localparam int unsigned TW   = $clog2(PER),
  localparam int unsigned ZW   = $clog2(NTAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          last_i,
  output logic          go_o,
  output logic          zero_o,
  output logic [TW-1:0] t_o,
  output logic          busy_o,
  output logic          end_o,
  output logic          idle_o
);
  localparam logic [TW-1:0] LastT = TW'(PER - 1);
  localparam logic [ZW-1:0] Flush = ZW'(NTAPS - 1);

  logic          busy_q, zero_q, last_q;
  logic [TW-1:0] cnt_q;
  logic [ZW-1:0] zleft_q;
  logic          accept, auto_go;

  assign idle_o  = !busy_q && (zleft_q == '0);
  assign accept  = idle_o && start_i;
  assign auto_go = !busy_q && (zleft_q != '0);
  assign go_o    = accept || auto_go;
  assign t_o     = busy_q ? cnt_q : '0;
  assign zero_o  = busy_q ? zero_q : auto_go;
  assign end_o   = busy_q && (cnt_q == LastT);
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      zero_q  <= 1'b0;
      last_q  <= 1'b0;
      cnt_q   <= '0;
      zleft_q <= '0;
    end else if (go_o) begin
      busy_q <= 1'b1;
      cnt_q  <= TW'(1);
      zero_q <= auto_go;
      last_q <= accept && last_i;
      if (auto_go) zleft_q <= zleft_q - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LastT) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        last_q <= 1'b0;
        if (last_q) zleft_q <= Flush;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsp_conv.sv
module bsp_conv import bsp_conv_pkg::*; #(
  parameter int unsigned DW    = DefDw,
  parameter int unsigned NTAPS = DefTaps,
  localparam int unsigned AW   = $clog2(NTAPS),
  localparam int unsigned OW   = sum_width(DW, NTAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          coef_we_i,
  input  logic [AW-1:0] coef_addr_i,
  input  logic [DW-1:0] coef_data_i,
  input  logic          bit_i,
  input  logic          start_i,
  input  logic          last_i,
  output logic [OW-1:0] y_o,
  output logic          valid_o
);
  localparam int unsigned PER = 2 * DW;
  localparam int unsigned TW  = $clog2(PER);
  localparam int unsigned BW  = $clog2(DW);
  localparam logic [TW-1:0] DwT = TW'(DW);

  logic          go, zero, busy, fin, idle, active, in_data, din;
  logic [TW-1:0] t_w;
  logic [BW-1:0] bsel;

  logic [DW-1:0] coef_q [NTAPS];
  logic [DW-1:0] hist_q [NTAPS-1];
  logic [DW-1:0] asm_q;
  logic [NTAPS-1:0] dbit, pbit;
  logic [OW-1:0] pop, ybase, ysum, yacc_q, y_q;
  logic          valid_q;

  bsp_conv_ctrl #(.NTAPS(NTAPS), .PER(PER)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .last_i (last_i),
    .go_o   (go),
    .zero_o (zero),
    .t_o    (t_w),
    .busy_o (busy),
    .end_o  (fin),
    .idle_o (idle)
  );

  assign active  = go || busy;
  assign in_data = (t_w < DwT);
  assign bsel    = t_w[BW-1:0];
  assign din     = in_data && !zero && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAPS; k++) coef_q[k] <= '0;
    end else if (coef_we_i && idle && (int'(coef_addr_i) < NTAPS)) begin
      coef_q[coef_addr_i] <= coef_data_i;
    end
  end

  // word-level pipeline between taps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q <= '0;
      for (int k = 0; k < NTAPS - 1; k++) hist_q[k] <= '0;
    end else begin
      if (active && in_data) asm_q[bsel] <= din;
      if (fin) begin
        hist_q[0] <= asm_q;
        for (int k = 1; k < NTAPS - 1; k++) hist_q[k] <= hist_q[k-1];
      end
    end
  end

  assign dbit[0] = din;
  for (genvar k = 1; k < NTAPS; k++) begin : g_dbit
    assign dbit[k] = in_data && hist_q[k-1][bsel];
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    bsp_conv_mul #(.DW(DW)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (active),
      .first_i(go),
      .d_i    (dbit[k]),
      .coef_i (coef_q[k]),
      .p_o    (pbit[k])
    );
  end

  always_comb begin
    pop = '0;
    for (int k = 0; k < NTAPS; k++) pop = pop + OW'(pbit[k]);
  end

  assign ybase = go ? '0 : yacc_q;
  assign ysum  = ybase + (pop << t_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yacc_q  <= '0;
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      if (active) yacc_q <= ysum;
      valid_q <= fin;
      if (fin) y_q <= ysum;
    end
  end

  assign y_o     = y_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/bsp_conv_chk.sv
module bsp_conv_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned NTAPS = 8,
  parameter int unsigned OW    = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [OW-1:0] y_i,
  input logic          busy_i,
  input logic [DW-1:0] coef_i [NTAPS]
);
  localparam longint unsigned MaxY =
    longint'(NTAPS) * ((longint'(1) << DW) - 1) * ((longint'(1) << DW) - 1);

  logic [NTAPS*DW-1:0] cpk;
  always_comb begin
    for (int k = 0; k < NTAPS; k++) cpk[k*DW +: DW] = coef_i[k];
  end

  a_r5_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  a_r5_valid_after_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(busy_i));

  a_r2_y_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (longint'(y_i) <= MaxY));

  a_r6_coef_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cpk));
endmodule

bind bsp_conv bsp_conv_chk #(.DW(DW), .NTAPS(NTAPS), .OW(OW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_o),
  .y_i    (y_o),
  .busy_i (busy),
  .coef_i (coef_q)
);

// File: tb/bsp_conv_tb.sv
module bsp_conv_tb;
  localparam int DW = 8;
  localparam int NT = 8;
  localparam int OW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [2:0] coef_addr = '0;
  logic [7:0] coef_data = '0;
  logic bit_in = 1'b0, start = 1'b0, last = 1'b0;
  logic [OW-1:0] y;
  logic valid;

  always #10 clk = ~clk;

  bsp_conv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .coef_we_i(coef_we), .coef_addr_i(coef_addr),
    .coef_data_i(coef_data), .bit_i(bit_in), .start_i(start), .last_i(last),
    .y_o(y), .valid_o(valid)
  );

  int total = 0, bad = 0, cyc = 0;
  int unsigned h_m [NT];
  logic [7:0] xs [32];
  longint unsigned exp_y [64];
  int exp_cyc [64];
  int n_exp = 0, got = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // result monitor (R2, R4, R5)
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (got < n_exp) begin
        check(longint'(y) == longint'(exp_y[got]), "R2 value", longint'(y), longint'(exp_y[got]));
        check(cyc == exp_cyc[got], "R5 timing", cyc, exp_cyc[got]);
      end else begin
        check(1'b0, "R4 extra output", got, n_exp);
      end
      got++;
    end
  end

  task automatic load(int a, int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 3'(a); coef_data = 8'(d);
    @(negedge clk);
    coef_we = 1'b0;
    h_m[a] = d;
  endtask

  task automatic set_expect(int m);
    n_exp = m + NT - 1;
    got = 0;
    for (int j = 0; j < n_exp; j++) begin
      longint unsigned s = 0;
      for (int n = 0; n < NT; n++)
        if (j - n >= 0 && j - n < m) s += longint'(h_m[n]) * longint'(xs[j-n]);
      exp_y[j] = s;
    end
  endtask

  task automatic run_seq(int m, int gap_max, bit poke_coef, bit poke_start);
    set_expect(m);
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      start = 1'b1; last = (i == m - 1); bit_in = xs[i][0];
      exp_cyc[i] = cyc + 16;
      for (int b = 1; b < 16; b++) begin
        @(negedge clk);
        start = 1'b0; last = 1'b0;
        bit_in = (b < DW) ? xs[i][b] : 1'b0;
        if (poke_coef && i == 1) begin
          // R6: write during streaming must be ignored
          coef_we = (b == 3); coef_addr = 3'd2; coef_data = ~8'(h_m[2]);
        end
      end
      coef_we = 1'b0;
      if (i < m - 1) begin
        int g = $urandom_range(gap_max, 0);
        repeat (g) @(negedge clk);
      end
    end
    for (int j = m; j < n_exp; j++) exp_cyc[j] = exp_cyc[j-1] + 16;
    for (int k = 0; k < 400 && got < n_exp; k++) begin
      @(negedge clk);
      // R7: stray start during flush
      start = poke_start && (k == 3);
      bit_in = poke_start && (k == 3);
    end
    start = 1'b0; bit_in = 1'b0;
    repeat (40) @(negedge clk);
    check(got == n_exp, "R4 output count", got, n_exp);
  endtask

  task automatic rand_coefs();
    for (int n = 0; n < NT; n++) load(n, $urandom_range(255, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f3a));
    for (int n = 0; n < NT; n++) h_m[n] = 0;
    repeat (3) @(negedge clk);
    check(y == '0 && !valid, "R1 in reset", longint'(y), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(y == '0 && !valid, "R1 after reset", longint'(y), 0);

    // R2/R3 random
    rand_coefs();
    for (int i = 0; i < 5; i++) xs[i] = 8'($urandom_range(255, 0));
    run_seq(5, 0, 1'b0, 1'b0);

    // R9 all 0xFF
    for (int n = 0; n < NT; n++) load(n, 255);
    for (int i = 0; i < 8; i++) xs[i] = 8'hff;
    run_seq(8, 0, 1'b0, 1'b0);
    check(exp_y[7] == 520200, "R9 model max", longint'(exp_y[7]), 520200);

    // zero data
    rand_coefs();
    for (int i = 0; i < 6; i++) xs[i] = 8'h00;
    run_seq(6, 2, 1'b0, 1'b0);

    // R8 single sample after clean flush: y[0] = h0*x0
    for (int n = 0; n < NT; n++) load(n, n * 31 + 7);
    xs[0] = 8'hc3;
    run_seq(1, 0, 1'b0, 1'b0);

    // R6 and R7 pokes
    rand_coefs();
    for (int i = 0; i < 6; i++) xs[i] = 8'($urandom_range(255, 0));
    run_seq(6, 1, 1'b1, 1'b1);

    // zero coefficients, full data
    for (int n = 0; n < NT; n++) load(n, 0);
    for (int i = 0; i < 4; i++) xs[i] = 8'hff;
    run_seq(4, 0, 1'b0, 1'b0);

    // random mix
    for (int r = 0; r < 8; r++) begin
      int m = $urandom_range(20, 1);
      rand_coefs();
      if (r == 2) load(0, 0);
      if (r == 3) load(7, 255);
      for (int i = 0; i < m; i++) xs[i] = 8'($urandom_range(255, 0));
      run_seq(m, 3, 1'b0, r == 5);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule